// File: doc/BRIEF.md
# Priority Round-Robin Transmit Merger

This block merges eight per-core transmit queues into the one egress FIFO in front of the Ethernet transmitter. Each queue is assigned a 3-bit priority class. The block always serves the highest class that has a queue ready. Within one class, the queues take turns. Each queue also has a token bucket. The bucket charges every packet its length plus the 20 bytes of fixed inter-packet spacing on the wire, so the limits are enforced in real line-time units.

A queue presents its head packet as a valid flag, a byte length and a stream of data beats that it shows one at a time. When the merger grants a queue, it reports the grant and then reads that whole packet, one beat per cycle, into the egress FIFO. It arbitrates again only after the last beat. It never starts a packet for which the FIFO lacks room.

Top module: `tx_prio_merger`

## Requirements
- R1: While reset is high and in the first cycle after it, gnt_valid, fifo_wr and every q_rd bit are 0. Every token bucket starts empty, and the first grant within any class goes to that class's lowest-numbered ready queue.
- R2: A queue is ready when q_valid is high, its length is nonzero and its token check passes. A grant always goes to a ready queue of the numerically highest class (7 highest, 0 lowest) present in the arbitration cycle.
- R3: Within a class, the search for the next winner starts at the queue after that class's previous winner and wraps around past queue NQ-1. Each class keeps its own turn pointer.
- R4: When a queue's limiter is on, the queue is ready only when its tokens are at least its head length plus 20.
- R5: While a queue's limiter is on, its tokens grow by cfg_refill each cycle and saturate at cfg_cap. A grant deducts length plus 20 from the saturated value in the same cycle.
- R6: A queue whose limiter is off is ready whenever it holds a packet, whatever its refill and cap settings.
- R7: A grant is issued only when fifo_space is at least the winner's beat count, ceil(length/8). Meanwhile the winner is held, and no other queue is granted in its place.
- R8: After a grant, the granted queue's q_rd bit alone is high for exactly ceil(length/8) consecutive cycles. Each beat on q_data appears on fifo_wdata with fifo_wr one cycle later, and fifo_last marks the final beat. There is no arbitration until that final beat is written.
- R9: gnt_valid is a one-cycle pulse that carries the granted queue index and length. It comes exactly one cycle before the packet's first fifo_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | NQ | Queue i holds a head packet |
| q_len | input | NQ*LEN_W | Head packet byte length, queue i at [i*LEN_W +: LEN_W] |
| q_data | input | NQ*DW | Current head beat, queue i at [i*DW +: DW] |
| q_rd | output | NQ | Advance queue i to its next beat |
| cfg_class | input | NQ*CLS_W | Priority class of queue i |
| cfg_rl_en | input | NQ | Rate limiter on for queue i |
| cfg_refill | input | NQ*TOK_W | Tokens (bytes) added per cycle |
| cfg_cap | input | NQ*TOK_W | Token bucket ceiling |
| fifo_space | input | SPACE_W | Free beats in the egress FIFO |
| fifo_wr | output | 1 | Write strobe to the egress FIFO |
| fifo_wdata | output | DW | Beat written to the egress FIFO |
| fifo_last | output | 1 | Written beat ends its packet |
| gnt_valid | output | 1 | Grant pulse |
| gnt_queue | output | QW | Granted queue index |
| gnt_len | output | LEN_W | Granted packet length |

## Verification
A table of backlog patterns runs with the limiters off.

- One packet in every queue of a single class shows whether the turn order starts at queue 0.
- Two queues raised above the rest tell strict priority apart from plain rotation.
- Queues with several packets each show whether the pointer advances past the winner rather than sticking to it.
- A pattern with two classes that each rotate shows that each class has its own pointer.

Directed cases cover the rest:

- A bucket capped one byte short of length plus 20 separates correct overhead charging from charging the length alone.
- Spacing between consecutive grants under a cap shows saturation and charging.
- A FIFO one beat short holds back both the winner and a smaller queue that would have fit.

// File: rtl/txm_pkg.sv
package txm_pkg;
  // Fixed per-packet line overhead charged by every rate limiter (bytes).
  localparam int unsigned WIRE_GAP_BYTES = 20;

  typedef enum logic {
    ST_ARB  = 1'b0,
    ST_MOVE = 1'b1
  } txm_state_e;
endpackage

// File: rtl/txm_token_bucket.sv
module txm_token_bucket
  import txm_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int TOK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rl_en,
  input  logic [TOK_W-1:0] refill,
  input  logic [TOK_W-1:0] cap,
  input  logic [LEN_W-1:0] head_len,
  input  logic             charge,
  output logic             tok_ok
);
  localparam int SW = TOK_W + 1;

  logic [TOK_W-1:0] tok_q;
  logic [SW-1:0]    cost, sum, sat, nxt;

  // Wire cost of the head packet: payload bytes plus fixed gap.
  assign cost = SW'(head_len) + SW'(WIRE_GAP_BYTES);
  assign sum  = {1'b0, tok_q} + {1'b0, refill};
  assign sat  = (sum > {1'b0, cap}) ? {1'b0, cap} : sum;

  always_comb begin
    nxt = sat;
    if (charge && (sat >= cost)) nxt = sat - cost;
  end

  always_ff @(posedge clk) begin
    if (rst)         tok_q <= '0;
    else if (!rl_en) tok_q <= cap;
    else             tok_q <= TOK_W'(nxt);
  end

  assign tok_ok = !rl_en || ({1'b0, tok_q} >= cost);
endmodule

// File: rtl/txm_rr_pick.sv
module txm_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // First requester strictly after 'last', wrapping; 'last' itself is tried last.
  always_comb begin
    hit = 1'b0;
    idx = last;
    for (int off = 1; off <= N; off++) begin
      int k;
      k = (int'(last) + off) % N;
      if (!hit && req[k]) begin
        hit = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/txm_class_arb.sv
module txm_class_arb #(
  parameter int NQ    = 8,
  parameter int CLS_W = 3,
  parameter int QW    = $clog2(NQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ-1:0]       req,
  input  logic [NQ*CLS_W-1:0] cls,
  input  logic                adv,
  output logic                hit,
  output logic [QW-1:0]       win,
  output logic [CLS_W-1:0]    win_cls
);
  localparam int NCLS = 1 << CLS_W;

  logic [NCLS-1:0]          c_hit;
  logic [NCLS-1:0][QW-1:0]  c_idx;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [NQ-1:0] member;
    logic [QW-1:0] last_r;

    for (genvar q = 0; q < NQ; q++) begin : g_m
      assign member[q] = req[q] && (cls[q*CLS_W +: CLS_W] == CLS_W'(c));
    end

    txm_rr_pick #(.N(NQ), .IW(QW)) u_pick (
      .req  (member),
      .last (last_r),
      .hit  (c_hit[c]),
      .idx  (c_idx[c])
    );

    // Reset to the top index so queue 0 is tried first.
    always_ff @(posedge clk) begin
      if (rst)                                  last_r <= QW'(NQ - 1);
      else if (adv && (win_cls == CLS_W'(c)))   last_r <= win;
    end
  end

  // Strict priority: the highest populated class overrides lower ones.
  always_comb begin
    hit     = 1'b0;
    win     = '0;
    win_cls = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (c_hit[c]) begin
        hit     = 1'b1;
        win     = c_idx[c];
        win_cls = CLS_W'(c);
      end
    end
  end
endmodule

// File: rtl/tx_prio_merger.sv
module tx_prio_merger
  import txm_pkg::*;
#(
  parameter int NQ         = 8,
  parameter int CLS_W      = 3,
  parameter int LEN_W      = 11,
  parameter int TOK_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int DW         = 64,
  parameter int SPACE_W    = 8,
  parameter int QW         = $clog2(NQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ-1:0]       q_valid,
  input  logic [NQ*LEN_W-1:0] q_len,
  input  logic [NQ*DW-1:0]    q_data,
  output logic [NQ-1:0]       q_rd,
  input  logic [NQ*CLS_W-1:0] cfg_class,
  input  logic [NQ-1:0]       cfg_rl_en,
  input  logic [NQ*TOK_W-1:0] cfg_refill,
  input  logic [NQ*TOK_W-1:0] cfg_cap,
  input  logic [SPACE_W-1:0]  fifo_space,
  output logic                fifo_wr,
  output logic [DW-1:0]       fifo_wdata,
  output logic                fifo_last,
  output logic                gnt_valid,
  output logic [QW-1:0]       gnt_queue,
  output logic [LEN_W-1:0]    gnt_len
);
  localparam int BSH = $clog2(BEAT_BYTES);
  localparam int BW  = LEN_W + 1;
  localparam int CW  = (BW > SPACE_W) ? BW : SPACE_W;

  txm_state_e        st_q;
  logic [QW-1:0]     sel_q;
  logic [BW-1:0]     cnt_q;

  logic [LEN_W-1:0]  len_a  [NQ];
  logic [DW-1:0]     data_a [NQ];
  logic [NQ-1:0]     tok_ok, cand, charge;

  logic              hit;
  logic [QW-1:0]     win;
  logic [CLS_W-1:0]  win_cls;
  logic [LEN_W-1:0]  win_len;
  logic [BW-1:0]     win_beats;
  logic              fits, grant;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign len_a[i]  = q_len[i*LEN_W +: LEN_W];
    assign data_a[i] = q_data[i*DW +: DW];
    assign charge[i] = grant && (win == QW'(i));
    assign cand[i]   = q_valid[i] && tok_ok[i] && (len_a[i] != '0);

    txm_token_bucket #(.LEN_W(LEN_W), .TOK_W(TOK_W)) u_tb (
      .clk      (clk),
      .rst      (rst),
      .rl_en    (cfg_rl_en[i]),
      .refill   (cfg_refill[i*TOK_W +: TOK_W]),
      .cap      (cfg_cap[i*TOK_W +: TOK_W]),
      .head_len (len_a[i]),
      .charge   (charge[i]),
      .tok_ok   (tok_ok[i])
    );
  end

  txm_class_arb #(.NQ(NQ), .CLS_W(CLS_W), .QW(QW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (cand),
    .cls     (cfg_class),
    .adv     (grant),
    .hit     (hit),
    .win     (win),
    .win_cls (win_cls)
  );

  assign win_len   = len_a[win];
  assign win_beats = ({1'b0, win_len} + BW'(BEAT_BYTES - 1)) >> BSH;
  // The chosen winner waits for room; nobody else is let past it.
  assign fits      = CW'(win_beats) <= CW'(fifo_space);
  assign grant     = (st_q == ST_ARB) && hit && fits;

  always_comb begin
    q_rd = '0;
    if (st_q == ST_MOVE) q_rd[sel_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_ARB;
      sel_q      <= '0;
      cnt_q      <= '0;
      gnt_valid  <= 1'b0;
      gnt_queue  <= '0;
      gnt_len    <= '0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      fifo_last  <= 1'b0;
    end else begin
      gnt_valid <= grant;
      fifo_wr   <= 1'b0;
      fifo_last <= 1'b0;
      case (st_q)
        ST_ARB: begin
          if (grant) begin
            st_q      <= ST_MOVE;
            sel_q     <= win;
            cnt_q     <= win_beats;
            gnt_queue <= win;
            gnt_len   <= win_len;
          end
        end
        ST_MOVE: begin
          fifo_wr    <= 1'b1;
          fifo_wdata <= data_a[sel_q];
          fifo_last  <= (cnt_q == BW'(1));
          cnt_q      <= cnt_q - BW'(1);
          if (cnt_q == BW'(1)) st_q <= ST_ARB;
        end
        default: st_q <= ST_ARB;
      endcase
    end
  end
endmodule

// File: rtl/txm_merger_checker.sv
module txm_merger_checker #(
  parameter int NQ         = 8,
  parameter int CLS_W      = 3,
  parameter int LEN_W      = 11,
  parameter int BEAT_BYTES = 8,
  parameter int SPACE_W    = 8,
  parameter int QW         = $clog2(NQ)
) (
  input logic                clk,
  input logic                rst,
  input logic [NQ-1:0]       q_rd,
  input logic [NQ-1:0]       cand,
  input logic [NQ*CLS_W-1:0] cfg_class,
  input logic [SPACE_W-1:0]  fifo_space,
  input logic                fifo_wr,
  input logic                fifo_last,
  input logic                gnt_valid,
  input logic [QW-1:0]       gnt_queue,
  input logic [LEN_W-1:0]    gnt_len
);
  localparam int BSH = $clog2(BEAT_BYTES);
  localparam int BW  = LEN_W + 1;
  localparam int CW  = (BW > SPACE_W) ? BW : SPACE_W;

  logic [CLS_W-1:0] hi_now, hi_prev;
  logic [CLS_W-1:0] cls_prev [NQ];
  logic [BW-1:0]    g_beats;

  always_comb begin
    hi_now = '0;
    for (int q = 0; q < NQ; q++)
      if (cand[q] && (cfg_class[q*CLS_W +: CLS_W] >= hi_now))
        hi_now = cfg_class[q*CLS_W +: CLS_W];
  end

  always_ff @(posedge clk) begin
    hi_prev <= hi_now;
    for (int q = 0; q < NQ; q++) cls_prev[q] <= cfg_class[q*CLS_W +: CLS_W];
  end

  assign g_beats = ({1'b0, gnt_len} + BW'(BEAT_BYTES - 1)) >> BSH;

  // R2: the winner's class is the top class among ready queues one cycle earlier
  a_r2_top_class: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (cls_prev[gnt_queue] == hi_prev));

  // R7: room for the whole packet existed in the arbitration cycle
  a_r7_room_at_grant: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (CW'(g_beats) <= CW'($past(fifo_space))));

  // R8: one queue is read at a time
  a_r8_rd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_rd));

  // R8: each read beat is written to the FIFO on the next cycle
  a_r8_rd_then_write: assert property (@(posedge clk) disable iff (rst)
    (|q_rd) |=> fifo_wr);

  // R8: end-of-packet marker only on a written beat
  a_r8_last_with_write: assert property (@(posedge clk) disable iff (rst)
    fifo_last |-> fifo_wr);

  // R9: a grant lasts one cycle and is followed by the first write
  a_r9_grant_pulse: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> (!gnt_valid && fifo_wr));
endmodule

bind tx_prio_merger txm_merger_checker #(
  .NQ(NQ), .CLS_W(CLS_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES),
  .SPACE_W(SPACE_W), .QW(QW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .q_rd       (q_rd),
  .cand       (cand),
  .cfg_class  (cfg_class),
  .fifo_space (fifo_space),
  .fifo_wr    (fifo_wr),
  .fifo_last  (fifo_last),
  .gnt_valid  (gnt_valid),
  .gnt_queue  (gnt_queue),
  .gnt_len    (gnt_len)
);

// File: tb/tx_prio_merger_bench.sv
`timescale 1ns/1ps
module tx_prio_merger_bench;
  localparam int NQ = 8, CLS_W = 3, LEN_W = 11, TOK_W = 16, DW = 64, SPACE_W = 8, QW = 3;
  localparam int LIMIT = 100000;

  typedef struct packed {
    logic [23:0] cls;
    logic [31:0] pend;
    logic [3:0]  n;
    logic [63:0] exp;
  } vec_t;

  // class map, backlog per queue (nibble i = queue i), grant count, expected order
  localparam vec_t VECS [5] = '{
    '{24'h000000, 32'h11111111, 4'd8, 64'h0000_0000_7654_3210},
    '{24'h140A00, 32'h11111111, 4'd8, 64'h0000_0000_7542_1063},
    '{24'h000091, 32'h00000222, 4'd6, 64'h0000_0000_0000_2121},
    '{24'hFFFFFF, 32'h00200003, 4'd5, 64'h0000_0000_0000_5050},
    '{24'h6031B0, 32'h10010120, 4'd5, 64'h0000_0000_0007_4121}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NQ-1:0]       q_valid;
  logic [NQ*LEN_W-1:0] q_len;
  logic [NQ*DW-1:0]    q_data;
  logic [NQ-1:0]       q_rd;
  logic [NQ*CLS_W-1:0] cfg_class = '0;
  logic [NQ-1:0]       cfg_rl_en = '0;
  logic [NQ*TOK_W-1:0] cfg_refill = '0;
  logic [NQ*TOK_W-1:0] cfg_cap = '0;
  logic [SPACE_W-1:0]  fifo_space = 8'd255;
  logic                fifo_wr, fifo_last, gnt_valid;
  logic [DW-1:0]       fifo_wdata;
  logic [QW-1:0]       gnt_queue;
  logic [LEN_W-1:0]    gnt_len;

  always #4 clk = ~clk;

  tx_prio_merger u_tx_prio_merger (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_len(q_len), .q_data(q_data),
    .q_rd(q_rd), .cfg_class(cfg_class), .cfg_rl_en(cfg_rl_en),
    .cfg_refill(cfg_refill), .cfg_cap(cfg_cap), .fifo_space(fifo_space),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_last(fifo_last),
    .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .gnt_len(gnt_len)
  );

  function automatic int beats_of(int len);
    return (len + 7) / 8;
  endfunction

  // ---------------- queue model ----------------
  int  qlen [NQ];
  int  pend [NQ];
  int  beat [NQ];
  int  ld_pend [NQ];
  logic ld = 1'b0;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      q_valid[i]               = pend[i] > 0;
      q_len[i*LEN_W +: LEN_W]  = LEN_W'(qlen[i]);
      q_data[i*DW +: DW]       = {48'd0, 8'(i), 8'(beat[i])};
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NQ; i++) begin
      if (ld) begin
        pend[i] <= ld_pend[i];
        beat[i] <= 0;
      end else if (q_rd[i]) begin
        if (beat[i] == beats_of(qlen[i]) - 1) begin
          beat[i] <= 0;
          pend[i] <= pend[i] - 1;
        end else begin
          beat[i] <= beat[i] + 1;
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- output monitor ----------------
  logic mclr = 1'b1;
  int nlog, bcnt, cq, cl, gcyc, mon_chk, mon_fail;
  int lq [32];
  int ll [32];
  int lc [32];
  bit pk_bad;

  initial begin
    mon_chk = 0; mon_fail = 0; nlog = 0; bcnt = 0; cq = 0; cl = 0; gcyc = 0; pk_bad = 0;
  end

  always @(negedge clk) begin
    if (mclr) begin
      nlog = 0; bcnt = 0; pk_bad = 0;
    end else begin
      if (gnt_valid) begin
        if (nlog < 32) begin
          lq[nlog] = int'(gnt_queue); ll[nlog] = int'(gnt_len); lc[nlog] = cyc;
        end
        nlog = nlog + 1;
        cq = int'(gnt_queue); cl = int'(gnt_len); gcyc = cyc;
      end
      if (fifo_wr) begin
        if (int'(fifo_wdata[15:8]) != cq || int'(fifo_wdata[7:0]) != bcnt) pk_bad = 1;
        if (bcnt == 0 && cyc != gcyc + 1) pk_bad = 1;   // R9 first write one cycle after grant
        bcnt = bcnt + 1;
        if (fifo_last) begin
          mon_chk = mon_chk + 1;
          if (pk_bad || bcnt != beats_of(cl)) begin
            mon_fail = mon_fail + 1;
            $display("FAIL R8/R9 packet from queue %0d: beats %0d bad=%0d, expected beats %0d bad=0",
                     cq, bcnt, pk_bad, beats_of(cl));
          end
          bcnt = 0; pk_bad = 0;
        end
      end
    end
  end

  // ---------------- checks ----------------
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; mclr = 1'b1; ld = 1'b1;
    for (int i = 0; i < NQ; i++) ld_pend[i] = 0;
    step(3);
    rst = 1'b0; mclr = 1'b0; ld = 1'b0;
  endtask

  task automatic load(input logic [31:0] p);
    for (int i = 0; i < NQ; i++) ld_pend[i] = int'(p[i*4 +: 4]);
    ld = 1'b1;
    step(1);
    ld = 1'b0;
  endtask

  task automatic base_cfg();
    cfg_class = '0; cfg_rl_en = '0; cfg_refill = '0; cfg_cap = '0;
    fifo_space = 8'd255;
    for (int i = 0; i < NQ; i++) qlen[i] = 64;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk + mon_chk - n_fail - mon_fail, n_chk + mon_chk);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin qlen[i] = 64; ld_pend[i] = 0; end
    base_cfg();
    do_reset();

    // R1: idle outputs right after reset
    check(gnt_valid == 1'b0, "R1 gnt_valid after reset", int'(gnt_valid), 0);
    check(fifo_wr == 1'b0, "R1 fifo_wr after reset", int'(fifo_wr), 0);
    check(q_rd == '0, "R1 q_rd after reset", int'(q_rd), 0);

    // R2 R3 R6: table of backlog patterns, limiters off with zero refill
    for (int v = 0; v < 5; v++) begin
      base_cfg();
      cfg_class = VECS[v].cls;
      do_reset();
      load(VECS[v].pend);
      step(200);
      check(nlog == int'(VECS[v].n), $sformatf("R6 grant count vector %0d", v), nlog, int'(VECS[v].n));
      for (int k = 0; k < int'(VECS[v].n); k++)
        check(lq[k] == int'(VECS[v].exp[k*4 +: 4]),
              $sformatf("R2 R3 order vector %0d slot %0d", v, k), lq[k], int'(VECS[v].exp[k*4 +: 4]));
    end

    // R4 R6: bucket one byte short of 64+20 blocks q0, unlimited q1 passes
    base_cfg();
    cfg_rl_en = 8'h01;
    cfg_refill[0 +: TOK_W] = 16'd83;
    cfg_cap[0 +: TOK_W] = 16'd83;
    do_reset();
    load(32'h00000011);
    step(100);
    check(nlog == 1, "R4 only one grant while q0 short of tokens", nlog, 1);
    check(lq[0] == 1, "R6 unlimited queue granted", lq[0], 1);
    qlen[0] = 63;
    step(40);
    check(nlog == 2, "R4 q0 granted once cost fits", nlog, 2);
    check(lq[1] == 0 && ll[1] == 63, "R4 R9 q0 grant length", ll[1], 63);

    // R5: refill 5/cycle, cap 100, three back-to-back packets of cost 84
    base_cfg();
    cfg_rl_en = 8'h01;
    cfg_refill[0 +: TOK_W] = 16'd5;
    cfg_cap[0 +: TOK_W] = 16'd100;
    do_reset();
    step(60);
    load(32'h00000003);
    step(80);
    check(nlog == 3, "R5 grants under cap", nlog, 3);
    check(lc[1] - lc[0] == 15, "R5 gap after first grant", lc[1] - lc[0], 15);
    check(lc[2] - lc[1] == 17, "R5 gap after second grant", lc[2] - lc[1], 17);

    // R7: FIFO one beat short holds winner q2 and does not let q3 pass
    base_cfg();
    qlen[3] = 8;
    fifo_space = 8'd7;
    do_reset();
    load(32'h00001100);
    step(50);
    check(nlog == 0, "R7 no grant without room", nlog, 0);
    fifo_space = 8'd8;
    step(40);
    check(nlog == 2, "R7 grants once room appears", nlog, 2);
    check(lq[0] == 2, "R7 held winner goes first", lq[0], 2);
    check(lq[1] == 3, "R7 small packet after", lq[1], 3);
    check(ll[0] == 64, "R9 grant reports length", ll[0], 64);

    summary();
    $finish;
  end
endmodule